// File: doc/BRIEF.md
# Reconfigurable Lookup Slice

This block models one slice of a reconfigurable logic fabric. It holds a row of lookup cells, two by default. Each cell owns sixteen storage bits that are addressed by four select inputs. A per-cell mode input decides what those bits are. In logic mode they are a truth table, so the cell computes any function of its four inputs. In RAM mode they form a 16x1 memory with a synchronous write and an asynchronous read. In shift mode they form a 16-bit serial shift register, with a selectable tap and a fixed cascade output at the far end.

Every cell output passes through a flip-flop stage. The stage has a synchronous reset and a clock enable, and a per-cell bypass select chooses between the registered value and the live lookup result. A configuration port loads a cell's whole table on a single clock edge.

Carry logic runs across the cells so that the slice can act as a small ripple adder. Each cell's lookup output serves as the propagate term, and select input 0 serves as the generate operand.

Top module: `lut_slice`

## Requirements
- R1: In logic mode (mode code 0), a cell's lut_o equals bit n of its table, where n is the unsigned value of its four select inputs with select input 0 as the least significant bit.
- R2: When a cell's cfg_we is high, the whole table of that cell takes cfg_data on that rising edge, whatever the mode. A load takes priority over a RAM write or a shift in the same cycle.
- R3: In RAM mode (mode code 1), a rising edge with wr_en high stores din at the table bit addressed by the selects. The other fifteen bits are left unchanged, and the read through lut_o is combinational.
- R4: In logic mode, wr_en and din have no effect on the table.
- R5: In shift mode (mode code 2), each rising edge with wr_en high moves bit i into bit i+1 and loads din into bit 0. In this mode lut_o is the tap chosen by the selects, and cascade_o is always the top bit (bit 15).
- R6: With bypass low, q_o is the cell's register. The register loads lut_o on a rising edge when ce is high and holds its value when ce is low.
- R7: A rising edge with rst high clears every register to 0, even when ce is low.
- R8: With bypass high, q_o equals lut_o in the same cycle.
- R9: Cell i computes the sum bit lut_o[i] XOR c[i] and the carry out (lut_o[i] ? c[i] : select input 0 of cell i). Here c[0] is cin and c[i+1] is the carry out of cell i. carry_o is the carry out of the last cell, so a table of in0 XOR in1 turns the slice into an adder.
- R10: Mode code 3 is reserved and never applied, and a cell's mode changes only in cycles where ce is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset of the output registers |
| ce | input | 1 | Clock enable of the output registers |
| mode_i | input | 2*NUM_CELLS | Mode code per cell (0 logic, 1 RAM, 2 shift) |
| cfg_we_i | input | NUM_CELLS | Table load strobe per cell |
| cfg_data_i | input | NUM_CELLS*16 | Table contents, cell i in bits [16i+15:16i] |
| sel_i | input | NUM_CELLS*4 | Select inputs, cell i in bits [4i+3:4i] |
| wr_en_i | input | NUM_CELLS | RAM write or shift strobe per cell |
| din_i | input | NUM_CELLS | RAM write data or serial input per cell |
| bypass_i | input | NUM_CELLS | 1 selects the combinational output onto q_o |
| cin_i | input | 1 | Carry into cell 0 |
| lut_o | output | NUM_CELLS | Combinational lookup result per cell |
| q_o | output | NUM_CELLS | Registered or bypassed result per cell |
| cascade_o | output | NUM_CELLS | Top table bit per cell |
| sum_o | output | NUM_CELLS | Sum bit per cell |
| carry_o | output | 1 | Carry out of the last cell |

## Verification
The bench builds the slice with its defaults: two cells with four select inputs each. With two cells, the carry from cell 0 to cell 1 is exercised, so a table of eight operand and carry-in patterns covers a full two-bit addition. Sixteen-bit tables are short enough to shift a marker bit all the way to the cascade output in a handful of cycles. Running one cell in RAM mode while the other stays in logic mode shows that the mode select acts on each cell separately.

// File: rtl/lut_slice_pkg.sv
package lut_slice_pkg;

   typedef enum logic [1:0] {
      MODE_LOGIC = 2'd0,
      MODE_RAM   = 2'd1,
      MODE_SHIFT = 2'd2
   } cell_mode_e;

endpackage

// File: rtl/lut_cell.sv
module lut_cell
   import lut_slice_pkg::*;
#(
   parameter int K = 4
) (
   input  logic               clk,
   input  logic               rst,
   input  cell_mode_e         mode_i,
   input  logic               cfg_we_i,
   input  logic [(1<<K)-1:0]  cfg_data_i,
   input  logic [K-1:0]       sel_i,
   input  logic               wr_en_i,
   input  logic               din_i,
   output logic               f_o,
   output logic               cascade_o
);

   localparam int DEPTH = 1 << K;

   if (K < 2 || K > 6) begin : g_bad_k
      $error("lut_cell: K must lie in 2..6");
   end

   logic [DEPTH-1:0] tbl;
   logic             ram_wr;
   logic             shift_en;

   assign ram_wr   = (mode_i == MODE_RAM)   && wr_en_i;
   assign shift_en = (mode_i == MODE_SHIFT) && wr_en_i;

   always_ff @(posedge clk) begin
      if (cfg_we_i)
         tbl <= cfg_data_i;
      else if (ram_wr)
         tbl[sel_i] <= din_i;
      else if (shift_en)
         tbl <= {tbl[DEPTH-2:0], din_i};
   end

   assign f_o       = tbl[sel_i];
   assign cascade_o = tbl[DEPTH-1];

   // R2
   cfg_load_chk: assert property (@(posedge clk) disable iff (rst)
      cfg_we_i |=> tbl == $past(cfg_data_i));

   // R4
   logic_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (mode_i == MODE_LOGIC && !cfg_we_i) |=> $stable(tbl));

   // R3
   ram_wr_chk: assert property (@(posedge clk) disable iff (rst)
      (mode_i == MODE_RAM && wr_en_i && !cfg_we_i) |=> tbl[$past(sel_i)] == $past(din_i));

   // R5
   shift_in_chk: assert property (@(posedge clk) disable iff (rst)
      (mode_i == MODE_SHIFT && wr_en_i && !cfg_we_i) |=> tbl[0] == $past(din_i));

endmodule

// File: rtl/slice_ff.sv
module slice_ff (
   input  logic clk,
   input  logic rst,
   input  logic ce,
   input  logic bypass_i,
   input  logic d_i,
   output logic q_o
);

   logic q_r;

   always_ff @(posedge clk) begin
      if (rst)
         q_r <= 1'b0;
      else if (ce)
         q_r <= d_i;
   end

   assign q_o = bypass_i ? d_i : q_r;

   // R7
   ff_reset_chk: assert property (@(posedge clk)
      rst |=> q_r == 1'b0);

   // R6
   ff_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !ce |=> q_r == $past(q_r));

endmodule

// File: rtl/carry_cell.sv
module carry_cell (
   input  logic prop_i,
   input  logic gen_i,
   input  logic cin_i,
   output logic sum_o,
   output logic cout_o
);

   assign sum_o  = prop_i ^ cin_i;
   assign cout_o = prop_i ? cin_i : gen_i;

endmodule

// File: rtl/lut_slice.sv
module lut_slice
   import lut_slice_pkg::*;
#(
   parameter int NUM_CELLS = 2,
   parameter int K         = 4
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         ce,
   input  logic [2*NUM_CELLS-1:0]       mode_i,
   input  logic [NUM_CELLS-1:0]         cfg_we_i,
   input  logic [NUM_CELLS*(1<<K)-1:0]  cfg_data_i,
   input  logic [NUM_CELLS*K-1:0]       sel_i,
   input  logic [NUM_CELLS-1:0]         wr_en_i,
   input  logic [NUM_CELLS-1:0]         din_i,
   input  logic [NUM_CELLS-1:0]         bypass_i,
   input  logic                         cin_i,
   output logic [NUM_CELLS-1:0]         lut_o,
   output logic [NUM_CELLS-1:0]         q_o,
   output logic [NUM_CELLS-1:0]         cascade_o,
   output logic [NUM_CELLS-1:0]         sum_o,
   output logic                         carry_o
);

   localparam int DEPTH = 1 << K;

   if (NUM_CELLS < 1) begin : g_bad_n
      $error("lut_slice: NUM_CELLS must be at least 1");
   end

   logic [NUM_CELLS:0] chain;
   assign chain[0] = cin_i;

   for (genvar i = 0; i < NUM_CELLS; i++) begin : g_cell
      cell_mode_e mode_c;
      assign mode_c = cell_mode_e'(mode_i[2*i +: 2]);

      lut_cell #(.K(K)) u_lut (
         .clk        (clk),
         .rst        (rst),
         .mode_i     (mode_c),
         .cfg_we_i   (cfg_we_i[i]),
         .cfg_data_i (cfg_data_i[DEPTH*i +: DEPTH]),
         .sel_i      (sel_i[K*i +: K]),
         .wr_en_i    (wr_en_i[i]),
         .din_i      (din_i[i]),
         .f_o        (lut_o[i]),
         .cascade_o  (cascade_o[i])
      );

      slice_ff u_ff (
         .clk      (clk),
         .rst      (rst),
         .ce       (ce),
         .bypass_i (bypass_i[i]),
         .d_i      (lut_o[i]),
         .q_o      (q_o[i])
      );

      carry_cell u_carry (
         .prop_i (lut_o[i]),
         .gen_i  (sel_i[K*i]),
         .cin_i  (chain[i]),
         .sum_o  (sum_o[i]),
         .cout_o (chain[i+1])
      );

      // R10
      mode_legal_chk: assert property (@(posedge clk) disable iff (rst)
         mode_i[2*i +: 2] != 2'b11);

      // R10
      mode_stable_chk: assert property (@(posedge clk) disable iff (rst)
         ce |-> $stable(mode_i[2*i +: 2]));
   end

   assign carry_o = chain[NUM_CELLS];

endmodule

// File: tb/sim_lut_slice.sv
module sim_lut_slice;

   localparam int N = 2;
   localparam int K = 4;
   localparam int NV = 8;
   // vector: a[7:6] b[5:4] cin[3] expected {carry, sum1, sum0}[2:0]
   localparam logic [7:0] VEC [NV] = '{
      {2'd0, 2'd0, 1'b0, 3'd0},
      {2'd1, 2'd1, 1'b0, 3'd2},
      {2'd3, 2'd1, 1'b0, 3'd4},
      {2'd3, 2'd3, 1'b1, 3'd7},
      {2'd2, 2'd1, 1'b1, 3'd4},
      {2'd1, 2'd2, 1'b0, 3'd3},
      {2'd3, 2'd0, 1'b1, 3'd4},
      {2'd2, 2'd2, 1'b0, 3'd4}
   };

   logic             clk = 1'b0;
   logic             rst;
   logic             ce;
   logic [2*N-1:0]   mode_i;
   logic [N-1:0]     cfg_we_i;
   logic [N*16-1:0]  cfg_data_i;
   logic [N*K-1:0]   sel_i;
   logic [N-1:0]     wr_en_i;
   logic [N-1:0]     din_i;
   logic [N-1:0]     bypass_i;
   logic             cin_i;
   logic [N-1:0]     lut_o;
   logic [N-1:0]     q_o;
   logic [N-1:0]     cascade_o;
   logic [N-1:0]     sum_o;
   logic             carry_o;

   int total = 0;
   int bad   = 0;

   always #4 clk = ~clk;

   lut_slice #(.NUM_CELLS(N), .K(K)) u0 (
      .clk, .rst, .ce, .mode_i, .cfg_we_i, .cfg_data_i, .sel_i,
      .wr_en_i, .din_i, .bypass_i, .cin_i,
      .lut_o, .q_o, .cascade_o, .sum_o, .carry_o
   );

   task automatic tick;
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   initial begin
      #800000;
      bad++;
      total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst = 1'b1; ce = 1'b0; mode_i = '0; cfg_we_i = '0; cfg_data_i = '0;
      sel_i = '0; wr_en_i = '0; din_i = '0; bypass_i = '0; cin_i = 1'b0;
      tick;
      // both tables = in0 XOR in1
      cfg_we_i = 2'b11; cfg_data_i = {16'h6666, 16'h6666};
      tick;
      cfg_we_i = '0;
      tick;
      chk("R7 reset state q_o", q_o, 2'b00);
      rst = 1'b0;
      tick;

      // R9 vector table: two-bit adder
      for (int v = 0; v < NV; v++) begin
         logic [1:0] a, b;
         logic [1:0] hi;
         a = VEC[v][7:6]; b = VEC[v][5:4]; hi = v[1:0];
         sel_i = {~hi, b[1], a[1], hi, b[0], a[0]};
         cin_i = VEC[v][3];
         #1;
         chk("R9 adder {carry,sum}", {carry_o, sum_o}, VEC[v][2:0]);
      end
      cin_i = 1'b0;

      // R1 logic mode: 4-input AND in cell 0
      cfg_we_i = 2'b01; cfg_data_i = {16'h6666, 16'h8000};
      tick;
      cfg_we_i = '0;
      sel_i = {4'd0, 4'd15}; #1;
      chk("R1 AND at 15", lut_o[0], 1'b1);
      sel_i = {4'd0, 4'd14}; #1;
      chk("R1 AND at 14", lut_o[0], 1'b0);

      // R4 wr_en ignored in logic mode
      sel_i = {4'd0, 4'd15}; wr_en_i = 2'b01; din_i = 2'b00;
      tick;
      wr_en_i = '0; #1;
      chk("R4 logic table unchanged", lut_o[0], 1'b1);

      // R8 bypass follows combinationally
      bypass_i = 2'b01; sel_i = {4'd0, 4'd14}; #1;
      chk("R8 bypass low value", q_o[0], 1'b0);
      sel_i = {4'd0, 4'd15}; #1;
      chk("R8 bypass high value", q_o[0], 1'b1);
      bypass_i = '0;

      // R6 register load and hold
      ce = 1'b1;
      tick;
      chk("R6 register load", q_o[0], 1'b1);
      ce = 1'b0; sel_i = {4'd0, 4'd3};
      tick;
      chk("R6 register hold while ce low", q_o[0], 1'b1);
      ce = 1'b1;
      tick;
      chk("R6 register reload", q_o[0], 1'b0);
      sel_i = {4'd0, 4'd15};
      tick;
      ce = 1'b0;
      // R7 reset dominates ce low
      rst = 1'b1;
      tick;
      rst = 1'b0;
      chk("R7 reset with ce low", q_o[0], 1'b0);

      // R3 RAM mode on cell 1, cell 0 stays logic
      mode_i = {2'd1, 2'd0};
      tick;
      sel_i = {4'd5, 4'd15}; wr_en_i = 2'b10; din_i = 2'b00;
      tick;
      wr_en_i = '0; #1;
      chk("R3 RAM written bit 5", lut_o[1], 1'b0);
      sel_i = {4'd6, 4'd15}; #1;
      chk("R3 RAM neighbour bit 6 kept", lut_o[1], 1'b1);
      sel_i = {4'd0, 4'd15}; wr_en_i = 2'b10; din_i = 2'b10;
      tick;
      wr_en_i = '0; #1;
      chk("R3 RAM written bit 0", lut_o[1], 1'b1);
      chk("R1 cell 0 unaffected", lut_o[0], 1'b1);

      // R2 load wins over RAM write in the same cycle
      cfg_we_i = 2'b10; cfg_data_i = {16'h00F0, 16'h8000};
      wr_en_i = 2'b10; din_i = 2'b10; sel_i = {4'd0, 4'd15};
      tick;
      cfg_we_i = '0; wr_en_i = '0; #1;
      chk("R2 load priority bit 0", lut_o[1], 1'b0);
      sel_i = {4'd4, 4'd15}; #1;
      chk("R2 loaded bit 4", lut_o[1], 1'b1);

      // R5 shift mode on cell 0
      mode_i = {2'd1, 2'd2};
      cfg_we_i = 2'b01; cfg_data_i = {16'h00F0, 16'h0000};
      tick;
      cfg_we_i = '0;
      foreach (VEC[j]) begin
         if (j < 4) begin
            din_i = {1'b0, (j != 1)};
            wr_en_i = 2'b01;
            tick;
         end
      end
      wr_en_i = '0;
      sel_i = {4'd4, 4'd3}; #1;
      chk("R5 tap 3 holds first bit", lut_o[0], 1'b1);
      sel_i = {4'd4, 4'd2}; #1;
      chk("R5 tap 2 holds second bit", lut_o[0], 1'b0);
      chk("R5 cascade before fill", cascade_o[0], 1'b0);
      din_i = '0; wr_en_i = 2'b01;
      for (int s = 0; s < 12; s++) tick;
      wr_en_i = '0; #1;
      chk("R5 cascade after 16 shifts", cascade_o[0], 1'b1);
      sel_i = {4'd4, 4'd15}; #1;
      chk("R5 tap 15 equals cascade", lut_o[0], 1'b1);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule